// File: doc/BRIEF.md
# Nibble-Wide Host Register Interface

This block sits between a slow host processor and the tone transceiver core. The host addresses it through a 4-bit data bus, an active-low select, a register-select line, a read/write line and a strobe that the host toggles whenever it wants a transfer. The strobe does not have to run continuously. The block keeps two host-writable nibbles: a control nibble and a transmit-tone nibble. It can return two core-supplied nibbles: a status nibble and a received-tone nibble. It decides when the bus drives out. A power-down input parks the whole block in an idle state.

All host lines, power-down included, pass through a two-flop synchronizer into the system clock domain. The strobe edges are found there. A four-state machine sequences the work. It has these states: `ST_OFF` (powered down), `ST_IDLE` (waiting for a strobe edge), `ST_COMMIT` (one cycle, writes the selected register) and `ST_LAUNCH` (one cycle, loads the read latch).

The transitions are:
- `ST_OFF` → `ST_IDLE`: when the synchronized power-down is 0.
- `ST_IDLE` → `ST_COMMIT`: on a falling strobe with select low and read/write at 0.
- `ST_IDLE` → `ST_LAUNCH`: on a rising strobe with select low and read/write at 1.
- `ST_COMMIT` → `ST_IDLE` and `ST_LAUNCH` → `ST_IDLE`: unconditionally.
- Any state → `ST_OFF`: whenever the synchronized power-down is 1.

Out of reset the block is in `ST_OFF`. The bus is split into an input, an output and an output enable so that the pad ring can build the tristate driver. The pad ring also provides the idle levels of unconnected pins: select, register-select, read/write, strobe and data pull to 0, and power-down pulls to 1.

Top module: `hreg_top`

## Requirements
- R1: A falling strobe while select = 0, read/write = 0 and register-select = 1 stores the bus nibble in `ctrl_o`. The new value shows on the third clock edge after the edge that first samples the low strobe.
- R2: A falling strobe while select = 0, read/write = 0 and register-select = 0 stores the bus nibble in `tx_tone_o`. Each such write raises `tx_new_o` for exactly one clock cycle.
- R3: Writes are ignored when select = 1 or read/write = 1, and a rising strobe never writes. In these cases `ctrl_o`, `tx_tone_o` and the count of `tx_new_o` pulses stay unchanged.
- R4: A rising strobe while select = 0 and read/write = 1 latches a nibble into `bus_o`: `status_i` when register-select = 1, `rx_tone_i` when register-select = 0. `bus_o` holds that value until the next such read.
- R5: `bus_oe_o` is 1 exactly when the synchronized select is 0, the synchronized read/write is 1 and the block is not powered down.
- R6: While power-down = 1, `ctrl_o`, `tx_tone_o` and `bus_o` are 0, `bus_oe_o` is 0, and strobes have no effect, both during power-down and after it is released.
- R7: After reset, `ctrl_o`, `tx_tone_o` and `bus_o` are 0, and `bus_oe_o` and `tx_new_o` are 0.
- R8: A write to the control register never pulses `tx_new_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_i | input | 1 | Power-down request, 1 = powered down |
| hstb_i | input | 1 | Host strobe, aperiodic |
| hsel_n_i | input | 1 | Host select, active low |
| hreg_i | input | 1 | Register select: 1 = control/status, 0 = tone transmit/receive |
| hrd_i | input | 1 | 1 = read, 0 = write |
| bus_i | input | DW | Bus value from the pads |
| bus_o | output | DW | Read data to the pads |
| bus_oe_o | output | 1 | Pad output enable |
| status_i | input | DW | Status nibble from the core |
| rx_tone_i | input | DW | Received-tone nibble from the detector |
| ctrl_o | output | DW | Control register |
| tx_tone_o | output | DW | Transmit-tone register |
| tx_new_o | output | 1 | One-cycle pulse on each transmit-tone write |

## Verification
The assertions assume that the host holds select, read/write, register-select and data stable for at least four system clock cycles around each strobe edge. They also assume that each strobe level lasts at least four cycles. Under these assumptions the synchronized copies still carry the same transfer when `ST_COMMIT` or `ST_LAUNCH` acts, and no strobe edge is missed.

The `status_i` and `rx_tone_i` inputs are assumed steady around a read. The stimulus respects all of this:
- It changes host lines only on falling clock edges.
- It waits five cycles between any two host events.
- It changes the core nibbles only while no strobe is in flight.
- It randomizes only the values of the host lines, never their timing.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_COMMIT = 2'd2,
        ST_LAUNCH = 2'd3
    } hreg_state_e;
endpackage

// File: rtl/hreg_sync.sv
module hreg_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hreg_fsm.sv
module hreg_fsm
    import hreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pdn_s,
    input  logic        stb_s,
    input  logic        sel_n_s,
    input  logic        rd_s,
    output hreg_state_e state_o
);
    hreg_state_e state_q, state_d;
    logic        stb_prev_q;
    logic        stb_rise, stb_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_prev_q <= 1'b0;
        else        stb_prev_q <= stb_s;
    end

    assign stb_rise = stb_s & ~stb_prev_q;
    assign stb_fall = ~stb_s & stb_prev_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (pdn_s) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:    state_d = ST_IDLE;
                ST_IDLE: begin
                    if (stb_fall && !sel_n_s && !rd_s)     state_d = ST_COMMIT;
                    else if (stb_rise && !sel_n_s && rd_s) state_d = ST_LAUNCH;
                end
                ST_COMMIT: state_d = ST_IDLE;
                ST_LAUNCH: state_d = ST_IDLE;
            endcase
        end
    end

    assign state_o = state_q;

    // R6: a power-down request always lands in the off state
    a_r6_pdn_to_off: assert property (@(posedge clk) disable iff (!rst_n)
        pdn_s |=> state_q == ST_OFF);
    // R1: a commit lasts one cycle only
    a_r1_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_COMMIT |=> state_q != ST_COMMIT);
    // R4: a launch lasts one cycle only
    a_r4_launch_single: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LAUNCH |=> state_q != ST_LAUNCH);
endmodule

// File: rtl/hreg_regs.sv
module hreg_regs
    import hreg_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  hreg_state_e   state_i,
    input  logic          reg_s,
    input  logic [DW-1:0] data_s,
    input  logic [DW-1:0] status_i,
    input  logic [DW-1:0] rx_tone_i,
    output logic [DW-1:0] ctrl_o,
    output logic [DW-1:0] tx_tone_o,
    output logic          tx_new_o,
    output logic [DW-1:0] rdat_o
);
    logic [DW-1:0] ctrl_q, tx_q, rdat_q;
    logic          new_q;

    // output process: actions taken in each state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            tx_q   <= '0;
            rdat_q <= '0;
            new_q  <= 1'b0;
        end else begin
            new_q <= 1'b0;
            unique case (state_i)
                ST_OFF: begin
                    ctrl_q <= '0;
                    tx_q   <= '0;
                    rdat_q <= '0;
                end
                ST_IDLE: ;
                ST_COMMIT: begin
                    if (reg_s) begin
                        ctrl_q <= data_s;
                    end else begin
                        tx_q  <= data_s;
                        new_q <= 1'b1;
                    end
                end
                ST_LAUNCH: rdat_q <= reg_s ? status_i : rx_tone_i;
            endcase
        end
    end

    assign ctrl_o    = ctrl_q;
    assign tx_tone_o = tx_q;
    assign tx_new_o  = new_q;
    assign rdat_o    = rdat_q;

    a_r6_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        state_i == ST_OFF |=> (ctrl_q == '0 && tx_q == '0 && rdat_q == '0));
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_IDLE || state_i == ST_LAUNCH) |=> ($stable(ctrl_q) && $stable(tx_q)));
    a_r2_pulse_one: assert property (@(posedge clk) disable iff (!rst_n)
        new_q |=> !new_q);
    a_r4_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_IDLE || state_i == ST_COMMIT) |=> $stable(rdat_q));
    a_r8_ctrl_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_COMMIT && reg_s) |=> !new_q);
endmodule

// File: rtl/hreg_top.sv
module hreg_top
    import hreg_pkg::*;
#(
    parameter int DW      = 4,
    parameter int STAGES  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pdn_i,
    input  logic          hstb_i,
    input  logic          hsel_n_i,
    input  logic          hreg_i,
    input  logic          hrd_i,
    input  logic [DW-1:0] bus_i,
    output logic [DW-1:0] bus_o,
    output logic          bus_oe_o,
    input  logic [DW-1:0] status_i,
    input  logic [DW-1:0] rx_tone_i,
    output logic [DW-1:0] ctrl_o,
    output logic [DW-1:0] tx_tone_o,
    output logic          tx_new_o
);
    localparam int SW = DW + 5;
    localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, {DW{1'b0}}};

    logic [SW-1:0] raw, synced;
    logic          pdn_s, stb_s, sel_n_s, rd_s, reg_s;
    logic [DW-1:0] data_s;
    hreg_state_e   state;

    assign raw = {pdn_i, hstb_i, hsel_n_i, hrd_i, hreg_i, bus_i};

    hreg_sync #(.WIDTH(SW), .STAGES(STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(synced)
    );

    assign {pdn_s, stb_s, sel_n_s, rd_s, reg_s, data_s} = synced;

    hreg_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pdn_s(pdn_s), .stb_s(stb_s),
        .sel_n_s(sel_n_s), .rd_s(rd_s), .state_o(state)
    );

    hreg_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .state_i(state), .reg_s(reg_s),
        .data_s(data_s), .status_i(status_i), .rx_tone_i(rx_tone_i),
        .ctrl_o(ctrl_o), .tx_tone_o(tx_tone_o), .tx_new_o(tx_new_o),
        .rdat_o(bus_o)
    );

    assign bus_oe_o = (state != ST_OFF) && !sel_n_s && rd_s;

    // R5: the bus never drives in a write cycle
    a_r5_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_s || sel_n_s) |-> !bus_oe_o);
    // R2: a transmit pulse only follows a transmit write
    a_r2_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
        tx_new_o |-> $past(state == ST_COMMIT && !reg_s));
endmodule

// File: tb/tb_hreg_top.sv
module tb_hreg_top;
    localparam int PERIOD = 10;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pdn_i = 1'b1, hstb_i = 1'b0, hsel_n_i = 1'b1, hreg_i = 1'b0, hrd_i = 1'b0;
    logic [DW-1:0] bus_i = '0, status_i = '0, rx_tone_i = '0;
    logic [DW-1:0] bus_o, ctrl_o, tx_tone_o;
    logic          bus_oe_o, tx_new_o;

    int total = 0, bad = 0, pulses = 0;
    logic [DW-1:0] m_ctrl = '0, m_tx = '0, m_bus = '0;
    int            m_pulses = 0;
    bit            m_pdn = 1'b1;

    always #(PERIOD/2) clk = ~clk;

    hreg_top #(.DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .pdn_i(pdn_i), .hstb_i(hstb_i),
        .hsel_n_i(hsel_n_i), .hreg_i(hreg_i), .hrd_i(hrd_i), .bus_i(bus_i),
        .bus_o(bus_o), .bus_oe_o(bus_oe_o), .status_i(status_i),
        .rx_tone_i(rx_tone_i), .ctrl_o(ctrl_o), .tx_tone_o(tx_tone_o),
        .tx_new_o(tx_new_o)
    );

    always @(posedge clk) if (rst_n && tx_new_o) pulses <= pulses + 1;

    function automatic bit exp_oe(bit sel_n, bit rd, bit pdn);
        return !sel_n && rd && !pdn;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_state(string req);
        chk({req, " ctrl"}, ctrl_o, m_ctrl);
        chk({req, " tx"}, tx_tone_o, m_tx);
        chk({req, " bus"}, bus_o, m_bus);
        chk({req, " pulses"}, pulses, m_pulses);
    endtask

    task automatic set_pdn(bit v);
        @(negedge clk);
        pdn_i = v;
        m_pdn = v;
        if (v) begin m_ctrl = '0; m_tx = '0; m_bus = '0; end
        repeat (5) @(negedge clk);
        chk("R6 oe in power-down", bus_oe_o, 0);
        check_state("R6");
    endtask

    task automatic host_op(bit sel_n, bit rd, bit rsel, logic [DW-1:0] d, string req);
        @(negedge clk);
        hsel_n_i = sel_n; hrd_i = rd; hreg_i = rsel; bus_i = d;
        repeat (5) @(negedge clk);
        chk({req, "/R5 oe"}, bus_oe_o, exp_oe(sel_n, rd, m_pdn));
        hstb_i = 1'b1;
        repeat (5) @(negedge clk);
        if (!m_pdn && !sel_n && rd) m_bus = rsel ? status_i : rx_tone_i;
        check_state({req, " after rise"});
        hstb_i = 1'b0;
        repeat (5) @(negedge clk);
        if (!m_pdn && !sel_n && !rd) begin
            if (rsel) m_ctrl = d;
            else begin m_tx = d; m_pulses++; end
        end
        check_state({req, " after fall"});
        hsel_n_i = 1'b1; hrd_i = 1'b0;
        repeat (5) @(negedge clk);
        chk({req, "/R5 oe idle"}, bus_oe_o, 0);
    endtask

    initial begin
        #(PERIOD * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        chk("R7 ctrl", ctrl_o, 0);
        chk("R7 tx", tx_tone_o, 0);
        chk("R7 bus", bus_o, 0);
        chk("R7 oe", bus_oe_o, 0);
        chk("R7 pulse", tx_new_o, 0);
        // R6: strobes while powered down are ignored
        host_op(1'b0, 1'b0, 1'b1, 4'hA, "R6 write in pdn");
        host_op(1'b0, 1'b0, 1'b0, 4'h5, "R6 tx write in pdn");
        set_pdn(1'b0);
        // directed: R1, R2, R8, R3, R4
        host_op(1'b0, 1'b0, 1'b1, 4'hC, "R1 ctrl write");
        host_op(1'b0, 1'b0, 1'b1, 4'h3, "R8 ctrl write no pulse");
        host_op(1'b0, 1'b0, 1'b0, 4'h9, "R2 tx write");
        host_op(1'b0, 1'b0, 1'b0, 4'hF, "R2 tx write max");
        host_op(1'b1, 1'b0, 1'b1, 4'h0, "R3 deselected write");
        host_op(1'b0, 1'b1, 1'b0, 4'h1, "R3 read does not write");
        status_i = 4'h6; rx_tone_i = 4'hB;
        host_op(1'b0, 1'b1, 1'b1, 4'h0, "R4 status read");
        host_op(1'b0, 1'b1, 1'b0, 4'h0, "R4 rx read");
        rx_tone_i = 4'h2;
        host_op(1'b1, 1'b1, 1'b0, 4'h0, "R4 deselected read holds");
        // R6: power-down clears registers, release keeps them cleared
        set_pdn(1'b1);
        set_pdn(1'b0);
        // random
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            status_i  = DW'($urandom);
            rx_tone_i = DW'($urandom);
            if ($urandom_range(0, 19) == 0) set_pdn(~m_pdn);
            host_op(1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom),
                    DW'($urandom), "R1/R2/R3/R4 random");
        end
        set_pdn(1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule